// File: doc/BRIEF.md
# Symbolic Operand Address Resolver

This block sits between instruction decode and the on-chip scratchpads of a graph-processing engine. The engine runs several shard threads at once. Each instruction names its memory operands symbolically, not by physical address. An operand gives a symbol class (destination-vertex data, source-vertex data or edge data) and a slot index, and it carries a feature dimension. The resolver turns such an operand into a buffer select and a physical word address. It does this from run-time state: the size of the current destination interval, and the source-vertex and edge counts of the shard that the issuing thread currently holds.

Destination data lives in one buffer that every thread shares. Source and edge data live in a second buffer. That buffer is cut into equal regions, one per shard thread, and each region starts at a base address derived from the thread number. Within a class, slot `k` begins after `k` earlier slots, and each slot holds element count times dimension words. The resolver also turns a size macro into a concrete length: the issuing shard's edge count, its source count, the interval size, or a literal. When an operand's slot would run past the end of its buffer or region, the resolver raises a fault. Each result is registered once and returned together with the tag of the instruction.

Top module: `operand_resolver`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and stays 0 until an operand is presented.
- R2: A request accepted with `in_valid`=1 produces `out_valid`=1 exactly one clock later, with `out_tag` equal to the request's `in_tag`. A cycle with `in_valid`=0 produces `out_valid`=0 one clock later.
- R3: Class code 0 (destination) selects `out_buf`=0. Its address is slot × interval size × dimension, and it is the same for every thread number.
- R4: Class code 1 (source) selects `out_buf`=1. Its address is thread × (SE_DEPTH/THREADS) + slot × source count of that thread × dimension.
- R5: Class code 2 (edge) selects `out_buf`=1. Its address is thread × (SE_DEPTH/THREADS) + slot × edge count of that thread × dimension.
- R6: `out_len` follows `in_len_sel`. Code 0 gives the literal `in_len_lit`. Code 1 gives the issuing thread's edge count. Code 2 gives its source count. Code 3 gives `ivl_size`.
- R7: `out_fault`=1 when (slot+1) × count × dimension exceeds the slot's limit. The count is the interval size, source count or edge count for class 0, 1 or 2. The limit is DST_DEPTH for class 0 and SE_DEPTH/THREADS for classes 1 and 2. Class code 3 always faults and gives `out_buf`=0. A faulting result carries `out_addr`=0.
- R8: A metadata write (`meta_we`) sets the edge and source counts of thread `meta_tid`. Both counts are 0 after reset. A request presented in a later cycle resolves with the new counts.
- R9: A metadata write to one thread leaves the addresses, lengths and faults that another thread resolves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meta_we | input | 1 | Write shard counts for one thread |
| meta_tid | input | TID_W | Thread whose counts are written |
| meta_edges | input | CNT_W | Edge count of that thread's shard |
| meta_srcs | input | CNT_W | Source-vertex count of that thread's shard |
| ivl_size | input | CNT_W | Size of the current destination interval |
| in_valid | input | 1 | Operand request valid |
| in_tag | input | TAG_W | Instruction tag |
| in_tid | input | TID_W | Issuing shard thread |
| in_cls | input | 2 | Symbol class: 0 destination, 1 source, 2 edge, 3 invalid |
| in_slot | input | SLOT_W | Symbol slot index within its class |
| in_dim | input | DIM_W | Feature dimension of the operand |
| in_len_sel | input | 2 | Length macro: 0 literal, 1 edges, 2 sources, 3 interval |
| in_len_lit | input | CNT_W | Literal length |
| out_valid | output | 1 | Result valid |
| out_tag | output | TAG_W | Tag of the resolved request |
| out_buf | output | 1 | 0 destination buffer, 1 source/edge buffer |
| out_addr | output | ADDR_W | Physical word address |
| out_len | output | CNT_W | Expanded length |
| out_fault | output | 1 | Slot out of bounds or invalid class |

## Verification
Every result field is due one clock after its request. The bench presents each request just after a falling edge and compares all the outputs at the next falling edge. This is after the single rising edge that registers them. Requests follow each other with no gaps, so the check at one falling edge covers the previous request while the next one is already driven. Metadata writes are issued and then allowed one full edge before any request reads them. This matches the one-cycle visibility rule. The expected address, length and fault are worked out by arithmetic from shadow copies of the counts.

// File: rtl/opres_pkg.sv
package opres_pkg;
  typedef enum logic [1:0] {
    SYM_DST  = 2'd0,
    SYM_SRC  = 2'd1,
    SYM_EDGE = 2'd2,
    SYM_NONE = 2'd3
  } sym_cls_e;

  typedef enum logic [1:0] {
    LEN_LIT   = 2'd0,
    LEN_EDGES = 2'd1,
    LEN_SRCS  = 2'd2,
    LEN_IVL   = 2'd3
  } len_sel_e;
endpackage

// File: rtl/shard_meta_regs.sv
module shard_meta_regs #(
  parameter int THREADS = 4,
  parameter int CNT_W   = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [TID_W-1:0] wtid,
  input  logic [CNT_W-1:0] wedges,
  input  logic [CNT_W-1:0] wsrcs,
  input  logic [TID_W-1:0] rtid,
  output logic [CNT_W-1:0] redges,
  output logic [CNT_W-1:0] rsrcs
);
  logic [CNT_W-1:0] edges_q [THREADS];
  logic [CNT_W-1:0] srcs_q  [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        edges_q[t] <= '0;
        srcs_q[t]  <= '0;
      end else if (we && (32'(wtid) == t)) begin
        edges_q[t] <= wedges;
        srcs_q[t]  <= wsrcs;
      end
    end
  end

  always_comb begin
    redges = '0;
    rsrcs  = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (32'(rtid) == t) begin
        redges = edges_q[t];
        rsrcs  = srcs_q[t];
      end
    end
  end
endmodule

// File: rtl/size_macro_expand.sv
module size_macro_expand
  import opres_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] lit,
  input  logic [CNT_W-1:0] edges,
  input  logic [CNT_W-1:0] srcs,
  input  logic [CNT_W-1:0] ivl,
  output logic [CNT_W-1:0] len
);
  always_comb begin
    unique case (len_sel_e'(sel))
      LEN_EDGES: len = edges;
      LEN_SRCS:  len = srcs;
      LEN_IVL:   len = ivl;
      default:   len = lit;
    endcase
  end
endmodule

// File: rtl/symbol_addr_calc.sv
module symbol_addr_calc
  import opres_pkg::*;
#(
  parameter int THREADS   = 4,
  parameter int DST_DEPTH = 1024,
  parameter int SE_DEPTH  = 2048,
  parameter int CNT_W     = 8,
  parameter int SLOT_W    = 2,
  parameter int DIM_W     = 4,
  localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int REGION   = SE_DEPTH / THREADS,
  localparam int ADDR_W   = $clog2((DST_DEPTH > SE_DEPTH) ? DST_DEPTH : SE_DEPTH)
) (
  input  logic [1:0]        cls,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DIM_W-1:0]  dim,
  input  logic [TID_W-1:0]  tid,
  input  logic [CNT_W-1:0]  edges,
  input  logic [CNT_W-1:0]  srcs,
  input  logic [CNT_W-1:0]  ivl,
  output logic              sel_se,
  output logic [ADDR_W-1:0] addr,
  output logic              fault
);
  logic [31:0] cnt, limit, base, stride, offset, slot_end;

  always_comb begin
    cnt    = 32'(ivl);
    limit  = 32'(DST_DEPTH);
    base   = '0;
    sel_se = 1'b0;
    unique case (sym_cls_e'(cls))
      SYM_SRC: begin
        cnt = 32'(srcs); limit = 32'(REGION);
        base = 32'(tid) * 32'(REGION); sel_se = 1'b1;
      end
      SYM_EDGE: begin
        cnt = 32'(edges); limit = 32'(REGION);
        base = 32'(tid) * 32'(REGION); sel_se = 1'b1;
      end
      default: ;
    endcase
    stride   = cnt * 32'(dim);
    offset   = 32'(slot) * stride;
    slot_end = offset + stride;
    fault    = (sym_cls_e'(cls) == SYM_NONE) || (slot_end > limit);
    addr     = fault ? '0 : ADDR_W'(base + offset);
  end
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver #(
  parameter int THREADS   = 4,
  parameter int DST_DEPTH = 1024,
  parameter int SE_DEPTH  = 2048,
  parameter int CNT_W     = 8,
  parameter int SLOT_W    = 2,
  parameter int DIM_W     = 4,
  parameter int TAG_W     = 4,
  localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int ADDR_W   = $clog2((DST_DEPTH > SE_DEPTH) ? DST_DEPTH : SE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meta_we,
  input  logic [TID_W-1:0]  meta_tid,
  input  logic [CNT_W-1:0]  meta_edges,
  input  logic [CNT_W-1:0]  meta_srcs,
  input  logic [CNT_W-1:0]  ivl_size,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [1:0]        in_cls,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [DIM_W-1:0]  in_dim,
  input  logic [1:0]        in_len_sel,
  input  logic [CNT_W-1:0]  in_len_lit,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_buf,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CNT_W-1:0]  out_len,
  output logic              out_fault
);
  logic [CNT_W-1:0]  cur_edges, cur_srcs, len_c;
  logic              se_c, fault_c;
  logic [ADDR_W-1:0] addr_c;

  shard_meta_regs #(.THREADS(THREADS), .CNT_W(CNT_W)) u_meta (
    .clk(clk), .rst(rst), .we(meta_we), .wtid(meta_tid),
    .wedges(meta_edges), .wsrcs(meta_srcs), .rtid(in_tid),
    .redges(cur_edges), .rsrcs(cur_srcs)
  );

  size_macro_expand #(.CNT_W(CNT_W)) u_len (
    .sel(in_len_sel), .lit(in_len_lit), .edges(cur_edges),
    .srcs(cur_srcs), .ivl(ivl_size), .len(len_c)
  );

  symbol_addr_calc #(
    .THREADS(THREADS), .DST_DEPTH(DST_DEPTH), .SE_DEPTH(SE_DEPTH),
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .DIM_W(DIM_W)
  ) u_addr (
    .cls(in_cls), .slot(in_slot), .dim(in_dim), .tid(in_tid),
    .edges(cur_edges), .srcs(cur_srcs), .ivl(ivl_size),
    .sel_se(se_c), .addr(addr_c), .fault(fault_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_buf   <= 1'b0;
      out_addr  <= '0;
      out_len   <= '0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_tag   <= in_tag;
        out_buf   <= se_c;
        out_addr  <= addr_c;
        out_len   <= len_c;
        out_fault <= fault_c;
      end
    end
  end
endmodule

// File: rtl/operand_resolver_chk.sv
module operand_resolver_chk #(
  parameter int DST_DEPTH = 1024,
  parameter int SE_DEPTH  = 2048,
  parameter int TAG_W     = 4,
  parameter int ADDR_W    = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [TAG_W-1:0]  in_tag,
  input logic [1:0]        in_cls,
  input logic              out_valid,
  input logic [TAG_W-1:0]  out_tag,
  input logic              out_buf,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_fault
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_TAG_ECHO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_tag == $past(in_tag))); // R2
  AST_DST_BUFFER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 2'd0) |=> !out_buf); // R3
  AST_SE_BUFFER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_cls == 2'd1 || in_cls == 2'd2)) |=> out_buf); // R4
  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 2'd3) |=> (out_fault && !out_buf)); // R7
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault) |-> (out_addr == '0)); // R7
  AST_DST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && !out_buf) |-> (32'(out_addr) < DST_DEPTH)); // R7
  AST_SE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && out_buf) |-> (32'(out_addr) < SE_DEPTH)); // R7
endmodule

bind operand_resolver operand_resolver_chk #(
  .DST_DEPTH(DST_DEPTH), .SE_DEPTH(SE_DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_operand_resolver.sv
module test_operand_resolver;
  localparam int THREADS = 4, DST_DEPTH = 1024, SE_DEPTH = 2048;
  localparam int CNT_W = 8, SLOT_W = 2, DIM_W = 4, TAG_W = 4;
  localparam int TID_W = 2, ADDR_W = 11, REGION = SE_DEPTH / THREADS;

  logic clk = 0, rst = 1;
  logic meta_we = 0;
  logic [TID_W-1:0] meta_tid = '0;
  logic [CNT_W-1:0] meta_edges = '0, meta_srcs = '0, ivl_size = '0;
  logic in_valid = 0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [TID_W-1:0] in_tid = '0;
  logic [1:0] in_cls = '0, in_len_sel = '0;
  logic [SLOT_W-1:0] in_slot = '0;
  logic [DIM_W-1:0] in_dim = '0;
  logic [CNT_W-1:0] in_len_lit = '0;
  logic out_valid, out_buf, out_fault;
  logic [TAG_W-1:0] out_tag;
  logic [ADDR_W-1:0] out_addr;
  logic [CNT_W-1:0] out_len;

  int errors = 0, checks = 0;
  bit done = 0;
  int sh_edges [THREADS];
  int sh_srcs  [THREADS];
  int tagc = 0;

  always #5 clk = ~clk;

  operand_resolver #(.THREADS(THREADS), .DST_DEPTH(DST_DEPTH), .SE_DEPTH(SE_DEPTH),
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .DIM_W(DIM_W), .TAG_W(TAG_W)) i_operand_resolver (
    .clk(clk), .rst(rst), .meta_we(meta_we), .meta_tid(meta_tid),
    .meta_edges(meta_edges), .meta_srcs(meta_srcs), .ivl_size(ivl_size),
    .in_valid(in_valid), .in_tag(in_tag), .in_tid(in_tid), .in_cls(in_cls),
    .in_slot(in_slot), .in_dim(in_dim), .in_len_sel(in_len_sel),
    .in_len_lit(in_len_lit), .out_valid(out_valid), .out_tag(out_tag),
    .out_buf(out_buf), .out_addr(out_addr), .out_len(out_len), .out_fault(out_fault));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_meta(int t, int e, int s);
    meta_we = 1; meta_tid = TID_W'(t);
    meta_edges = CNT_W'(e); meta_srcs = CNT_W'(s);
    sh_edges[t] = e; sh_srcs[t] = s;
    @(negedge clk);
    meta_we = 0;
  endtask

  // Drive one request at a falling edge, compare results at the next one.
  task automatic resolve(int t, int c, int sl, int d, int ls, int lit);
    int cnt, lim, base, stride, fault, addr, bsel, len, tg;
    string rq;
    tg = tagc % 16; tagc++;
    in_valid = 1; in_tag = TAG_W'(tg); in_tid = TID_W'(t); in_cls = 2'(c);
    in_slot = SLOT_W'(sl); in_dim = DIM_W'(d); in_len_sel = 2'(ls);
    in_len_lit = CNT_W'(lit);
    cnt = 32'(ivl_size); lim = DST_DEPTH; base = 0; bsel = 0; rq = "R3";
    if (c == 1) begin cnt = sh_srcs[t];  lim = REGION; base = t * REGION; bsel = 1; rq = "R4"; end
    if (c == 2) begin cnt = sh_edges[t]; lim = REGION; base = t * REGION; bsel = 1; rq = "R5"; end
    stride = cnt * d;
    fault = (c == 3 || (sl + 1) * stride > lim) ? 1 : 0;
    addr = fault ? 0 : base + sl * stride;
    len = (ls == 0) ? lit : (ls == 1) ? sh_edges[t] : (ls == 2) ? sh_srcs[t] : 32'(ivl_size);
    @(negedge clk);
    in_valid = 0;
    check("R2 valid", 32'(out_valid), 1);
    check("R2 tag", 32'(out_tag), tg);
    check({rq, " buf"}, 32'(out_buf), bsel);
    check("R7 fault", 32'(out_fault), fault);
    check({rq, " addr"}, 32'(out_addr), addr);
    check("R6 len", 32'(out_len), len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < THREADS; t++) begin sh_edges[t] = 0; sh_srcs[t] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset valid", 32'(out_valid), 0);
    // R8: counts are zero after reset, so a source slot has zero stride
    resolve(2, 1, 3, 5, 2, 9);
    ivl_size = 8'd60;
    for (int t = 0; t < THREADS; t++) write_meta(t, 10 + 13 * t, 5 + 7 * t);
    // Full sweep across threads, classes, slots, dims, length macros (R3..R7)
    for (int t = 0; t < THREADS; t++)
      for (int c = 0; c < 4; c++)
        for (int sl = 0; sl < 4; sl++)
          for (int di = 0; di < 5; di++)
            for (int ls = 0; ls < 4; ls++)
              resolve(t, c, sl, (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : (di == 3) ? 7 : 15,
                      ls, 17 + ls + sl);
    // R2: an idle cycle yields no result
    @(negedge clk);
    check("R2 idle", 32'(out_valid), 0);
    // R8: update thread 1, next request sees new counts
    write_meta(1, 100, 3);
    resolve(1, 2, 1, 2, 1, 0);
    resolve(1, 1, 2, 4, 2, 0);
    // R9: thread 0 and 3 unaffected by the write to thread 1
    resolve(0, 2, 3, 7, 1, 0);
    resolve(3, 1, 2, 3, 2, 0);
    // R7: exact-fit boundary: (3+1)*32*4 = 512 is in range, 33 overflows
    write_meta(2, 32, 33);
    resolve(2, 2, 3, 4, 1, 0);
    resolve(2, 1, 3, 4, 2, 0);
    // R3: destination address identical for all threads
    ivl_size = 8'd64;
    for (int t = 0; t < THREADS; t++) resolve(t, 0, 3, 4, 3, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule